// File: doc/BRIEF.md
# Polled Terminal Receive Port

This block is the receive side of a character terminal as seen by a processor over a simple synchronous register bus. It holds two 16-bit registers, a control/status word and a character buffer, and bit 1 of the bus address selects between them. An upstream deserializer presents each finished byte with a one-cycle strobe. The port stores the byte, masked to 7 or 8 bits by a static mode input, and sets a completion flag. When software has enabled interrupts, it also raises a level interrupt request.

Software either polls the completion flag or waits for the interrupt, and then reads the buffer. That read is the acknowledge: it clears the completion flag and withdraws the request in the same bus cycle. Only the enable bit can be written. If software turns the enable on while a character is already waiting, the request rises at once.

Top module: `term_rx_port`

## Requirements
- R1: Address bit 1 selects the register. 0 selects the control/status word and 1 selects the character buffer. Address bit 0 does not change which register a read returns.
- R2: A status read, which is combinational while busRead is high, returns the done flag in bit 7 and the interrupt enable in bit 6. Every other bit reads 0. busRData is 0 while busRead is low.
- R3: A buffer read returns the stored character in bits 7:0, with bits 15:8 at 0. After that clock edge, done is 0 and irqReq is 0.
- R4: A status write at an even address (bit 0 = 0) loads the enable from write-data bit 6. It leaves done and the buffer unchanged.
- R5: A status write at an odd address (bit 0 = 1) is ignored and changes no state.
- R6: irqReq is a registered level that is high exactly when done and enable are both set. Writing enable = 0 drops it on the next edge. Writing enable = 1 while done = 1 raises it on the next edge.
- R7: A write to the buffer address changes neither the buffer, the done flag nor the enable.
- R8: On a charValid strobe, the character is stored with bit 7 forced to 0 when mode8Bit = 0, or unchanged when mode8Bit = 1. Done is set, and irqReq rises if enable is set.
- R9: A character that arrives while done is still set overwrites the buffer. Done simply stays set, and there is no error indication.
- R10: Reset (rstN low) clears the buffer, done, the enable and irqReq.
- R11: If a character strobe and a buffer read fall in the same cycle, the read returns the old character. The new character is stored and done stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busAddr | input | 2 | Register address: bit 1 selects the register, bit 0 marks the odd byte |
| busWrite | input | 1 | Write strobe for this cycle |
| busRead | input | 1 | Read strobe for this cycle |
| busWData | input | 16 | Write data |
| busRData | output | 16 | Read data, combinational, 0 when not reading |
| charValid | input | 1 | One-cycle strobe for an incoming character |
| charIn | input | 8 | Incoming character |
| mode8Bit | input | 1 | 1 keeps 8-bit characters, 0 keeps 7 bits |
| irqReq | output | 1 | Level interrupt request |

## Verification
The hardest case to reach is a collision: a character strobe and a buffer read in the same cycle. Software never plans this, so it only happens by chance at the ports. The bench forces it by first loading a known character and then driving the second strobe and the buffer read together in one cycle. It checks the returned data combinationally before the edge, then reads the status to confirm that done survived. It also builds up the enable-after-done sequence and the overwrite-while-done sequence step by step in its vector table.

// File: rtl/term_rx_pkg.sv
package term_rx_pkg;
  localparam int DATA_W  = 16;
  localparam int CHAR_W  = 8;
  localparam int ADDR_W  = 2;
  localparam int DONE_IX = 7;
  localparam int IE_IX   = 6;
  localparam int SEL_IX  = 1;

  // strobes from the control block to the datapath
  typedef struct packed {
    logic loadChar;
    logic readBuf;
    logic readCsr;
  } rxStrobe_t;
endpackage

// File: rtl/term_rx_ctrl.sv
module term_rx_ctrl
  import term_rx_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int AW = ADDR_W,
  parameter int DONE_BIT = DONE_IX,
  parameter int IE_BIT = IE_IX,
  parameter int SEL_BIT = SEL_IX
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [AW-1:0] busAddr,
  input  logic          busWrite,
  input  logic          busRead,
  input  logic [DW-1:0] busWData,
  input  logic          charValid,
  output rxStrobe_t     strb,
  output logic          doneFlag,
  output logic          intEnable,
  output logic          irqReq
);
  logic selBuf, oddByte, wrCsr;
  logic ieNext, doneNext, irqNext;

  assign selBuf  = busAddr[SEL_BIT];
  assign oddByte = busAddr[0];
  assign wrCsr   = busWrite && !selBuf && !oddByte;

  assign strb.loadChar = charValid;
  assign strb.readBuf  = busRead && selBuf;
  assign strb.readCsr  = busRead && !selBuf;

  always_comb begin
    ieNext = wrCsr ? busWData[IE_BIT] : intEnable;
    if (charValid)         doneNext = 1'b1;
    else if (strb.readBuf) doneNext = 1'b0;
    else                   doneNext = doneFlag;
    if (charValid)         irqNext = ieNext;
    else if (strb.readBuf) irqNext = 1'b0;
    else if (wrCsr)        irqNext = busWData[IE_BIT] ? (irqReq | doneFlag) : 1'b0;
    else                   irqNext = irqReq;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      doneFlag  <= 1'b0;
      intEnable <= 1'b0;
      irqReq    <= 1'b0;
    end else begin
      doneFlag  <= doneNext;
      intEnable <= ieNext;
      irqReq    <= irqNext;
    end
  end

  // R6: request level tracks done and enable
  a_r6_irq_level: assert property (@(posedge clk) disable iff (!rstN)
    irqReq == (doneFlag && intEnable));
  // R3: buffer read acknowledges
  a_r3_read_acks: assert property (@(posedge clk) disable iff (!rstN)
    (busRead && selBuf && !charValid) |=> (!doneFlag && !irqReq));
  // R5: odd-byte status write is ignored
  a_r5_odd_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (busWrite && !selBuf && oddByte && !busRead && !charValid) |=>
      ($stable(intEnable) && $stable(doneFlag)));
  // R7: buffer write touches no status
  a_r7_bufwr_noeff: assert property (@(posedge clk) disable iff (!rstN)
    (busWrite && selBuf && !busRead && !charValid) |=>
      ($stable(intEnable) && $stable(doneFlag)));
  // R8: arriving character sets done
  a_r8_char_done: assert property (@(posedge clk) disable iff (!rstN)
    charValid |=> doneFlag);
endmodule

// File: rtl/term_rx_datapath.sv
module term_rx_datapath
  import term_rx_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int CW = CHAR_W,
  parameter int DONE_BIT = DONE_IX,
  parameter int IE_BIT = IE_IX
) (
  input  logic          clk,
  input  logic          rstN,
  input  rxStrobe_t     strb,
  input  logic [CW-1:0] charIn,
  input  logic          mode8Bit,
  input  logic          doneFlag,
  input  logic          intEnable,
  output logic [DW-1:0] busRData
);
  logic [CW-1:0] charBuf, charMask, maskedChar;
  logic [DW-1:0] csrWord;

  // top bit of the character kept only in 8-bit mode
  assign charMask   = {mode8Bit, {(CW-1){1'b1}}};
  assign maskedChar = charIn & charMask;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             charBuf <= '0;
    else if (strb.loadChar) charBuf <= maskedChar;
  end

  always_comb begin
    csrWord = '0;
    csrWord[DONE_BIT] = doneFlag;
    csrWord[IE_BIT]   = intEnable;
  end

  always_comb begin
    if (strb.readBuf)      busRData = {{(DW-CW){1'b0}}, charBuf};
    else if (strb.readCsr) busRData = csrWord;
    else                   busRData = '0;
  end

  // R8: 7-bit mode clears the top bit of the stored character
  a_r8_mask7: assert property (@(posedge clk) disable iff (!rstN)
    (strb.loadChar && !mode8Bit) |=> (charBuf[CW-1] == 1'b0));
  // R7: the buffer changes only on a character strobe
  a_r7_buf_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strb.loadChar |=> $stable(charBuf));
endmodule

// File: rtl/term_rx_port.sv
module term_rx_port
  import term_rx_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int CW = CHAR_W,
  parameter int AW = ADDR_W
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [AW-1:0] busAddr,
  input  logic          busWrite,
  input  logic          busRead,
  input  logic [DW-1:0] busWData,
  output logic [DW-1:0] busRData,
  input  logic          charValid,
  input  logic [CW-1:0] charIn,
  input  logic          mode8Bit,
  output logic          irqReq
);
  rxStrobe_t strb;
  logic doneFlag, intEnable;

  term_rx_ctrl #(.DW(DW), .AW(AW)) uCtrl (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrite(busWrite),
    .busRead(busRead), .busWData(busWData), .charValid(charValid),
    .strb(strb), .doneFlag(doneFlag), .intEnable(intEnable), .irqReq(irqReq)
  );

  term_rx_datapath #(.DW(DW), .CW(CW)) uData (
    .clk(clk), .rstN(rstN), .strb(strb), .charIn(charIn), .mode8Bit(mode8Bit),
    .doneFlag(doneFlag), .intEnable(intEnable), .busRData(busRData)
  );
endmodule

// File: tb/term_rx_port_test.sv
module term_rx_port_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [1:0] busAddr = '0;
  logic busWrite = 1'b0, busRead = 1'b0;
  logic [15:0] busWData = '0;
  logic [15:0] busRData;
  logic charValid = 1'b0;
  logic [7:0] charIn = '0;
  logic mode8Bit = 1'b0;
  logic irqReq;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  term_rx_port uut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrite(busWrite),
    .busRead(busRead), .busWData(busWData), .busRData(busRData),
    .charValid(charValid), .charIn(charIn), .mode8Bit(mode8Bit), .irqReq(irqReq)
  );

  // kind: 0 idle, 1 character, 2 write, 3 read
  typedef struct packed {
    logic [1:0]  kind;
    logic [1:0]  addr;
    logic [15:0] data;
    logic        mode8;
    logic [15:0] expRd;
    logic        expIrq;
  } vec_t;

  localparam int NVEC = 21;
  localparam vec_t VECS [NVEC] = '{
    '{2'd3, 2'd0, 16'h0000, 1'b0, 16'h0000, 1'b0}, // R2 status empty
    '{2'd1, 2'd0, 16'h00C5, 1'b0, 16'h0000, 1'b0}, // R8 7-bit char, ie off
    '{2'd3, 2'd0, 16'h0000, 1'b0, 16'h0080, 1'b0}, // R2 done bit 7
    '{2'd2, 2'd0, 16'hFFFF, 1'b0, 16'h0000, 1'b1}, // R4 R6 enable while done
    '{2'd3, 2'd0, 16'h0000, 1'b0, 16'h00C0, 1'b1}, // R2 R4 only ie written
    '{2'd2, 2'd1, 16'h0000, 1'b0, 16'h0000, 1'b1}, // R5 odd write ignored
    '{2'd3, 2'd0, 16'h0000, 1'b0, 16'h00C0, 1'b1}, // R5 state unchanged
    '{2'd2, 2'd2, 16'h00AA, 1'b0, 16'h0000, 1'b1}, // R7 buffer write
    '{2'd3, 2'd2, 16'h0000, 1'b0, 16'h0045, 1'b0}, // R3 R7 R8 read masked char
    '{2'd3, 2'd0, 16'h0000, 1'b0, 16'h0040, 1'b0}, // R3 done cleared
    '{2'd1, 2'd0, 16'h00C5, 1'b1, 16'h0000, 1'b1}, // R8 8-bit char, irq
    '{2'd1, 2'd0, 16'h003A, 1'b1, 16'h0000, 1'b1}, // R9 overwrite
    '{2'd3, 2'd0, 16'h0000, 1'b0, 16'h00C0, 1'b1}, // R9 no error bits
    '{2'd2, 2'd0, 16'h0000, 1'b0, 16'h0000, 1'b0}, // R6 disable drops irq
    '{2'd3, 2'd0, 16'h0000, 1'b0, 16'h0080, 1'b0}, // R6 done kept
    '{2'd3, 2'd2, 16'h0000, 1'b0, 16'h003A, 1'b0}, // R9 newest char
    '{2'd3, 2'd0, 16'h0000, 1'b0, 16'h0000, 1'b0}, // R3 cleared
    '{2'd3, 2'd3, 16'h0000, 1'b0, 16'h003A, 1'b0}, // R1 odd address reads buffer
    '{2'd2, 2'd0, 16'h0040, 1'b0, 16'h0000, 1'b0}, // R6 enable without done
    '{2'd1, 2'd0, 16'h0080, 1'b0, 16'h0000, 1'b1}, // R8 top bit masked, irq
    '{2'd3, 2'd2, 16'h0000, 1'b0, 16'h0000, 1'b0}  // R3 R8 reads zero
  };

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idleBus();
    busWrite = 1'b0; busRead = 1'b0; charValid = 1'b0;
    busAddr = '0; busWData = '0; charIn = '0;
  endtask

  // one bus cycle: drive after the falling edge, read data before the rising edge
  task automatic cycleRead(input logic [1:0] a, output logic [15:0] d);
    @(negedge clk);
    idleBus();
    busAddr = a; busRead = 1'b1;
    #1 d = busRData;
    @(posedge clk); #1;
    idleBus();
  endtask

  initial begin
    logic [15:0] rd;
    repeat (3) @(negedge clk);
    // R10: reset state
    check("R10 irq in reset", {15'b0, irqReq}, 16'h0000);
    rstN = 1'b1;
    // R2: no read strobe gives zero data
    @(negedge clk); #1;
    check("R2 idle read data", busRData, 16'h0000);

    for (int i = 0; i < NVEC; i++) begin
      @(negedge clk);
      idleBus();
      busAddr = VECS[i].addr;
      mode8Bit = VECS[i].mode8;
      case (VECS[i].kind)
        2'd1: begin charValid = 1'b1; charIn = VECS[i].data[7:0]; end
        2'd2: begin busWrite = 1'b1; busWData = VECS[i].data; end
        2'd3: busRead = 1'b1;
        default: ;
      endcase
      #1;
      if (VECS[i].kind == 2'd3)
        check($sformatf("vector %0d R1 R2 R3 read data", i), busRData, VECS[i].expRd);
      @(posedge clk); #1;
      check($sformatf("vector %0d R6 R8 irq", i), {15'b0, irqReq}, {15'b0, VECS[i].expIrq});
    end

    // R11: character and buffer read in the same cycle
    @(negedge clk); idleBus(); mode8Bit = 1'b1;
    charValid = 1'b1; charIn = 8'h11;
    @(negedge clk); idleBus();
    charValid = 1'b1; charIn = 8'h22; busRead = 1'b1; busAddr = 2'd2;
    #1 check("R11 collision returns old char", busRData, 16'h0011);
    @(posedge clk); #1;
    check("R11 irq stays with done", {15'b0, irqReq}, 16'h0001);
    cycleRead(2'd0, rd);
    check("R11 done survives", rd, 16'h00C0);
    cycleRead(2'd2, rd);
    check("R11 new char stored", rd, 16'h0022);

    // R10: reset clears a loaded port
    @(negedge clk); idleBus(); charValid = 1'b1; charIn = 8'h5A;
    @(negedge clk); idleBus();
    check("R10 irq before reset", {15'b0, irqReq}, 16'h0001);
    rstN = 1'b0;
    #1 check("R10 irq dropped", {15'b0, irqReq}, 16'h0000);
    @(negedge clk); rstN = 1'b1;
    cycleRead(2'd0, rd);
    check("R10 status cleared", rd, 16'h0000);
    cycleRead(2'd2, rd);
    check("R10 buffer cleared", rd, 16'h0000);

    finished = 1'b1;
  end

  initial begin
    fork
      wait (finished);
      begin
        repeat (20000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule